// File: doc/BRIEF.md
# Two-Step Interval Digitizer Controller

This block is the clocked back end of a capacitance readout that encodes a capacitance difference as the time between two comparator edges. Two comparator outputs, one on the sensor side and one on the reference side, rise while their capacitors charge. The earlier rising edge opens the interval and the later one closes it. The block latches which comparator fired first, which gives the sign. It then cuts the interval at rising clock edges into a leading fragment, a whole number of clock periods, and a trailing fragment. All counting uses a single slow clock.

A conversion starts with a request pulse while the block is idle. The block first asks the analog side to discharge and precharge its capacitors for one clock. It then waits for the comparator edges and counts whole periods. Each fragment gets a top bit from the level of the clock at the moment its edge arrived. High means the edge fell in the first half of the period, so the fragment is longer than half a period. The remaining three bits come from counting clocks while an external analog stretcher, which expands the leftover fragment sixteenfold, reports that it is busy. After a fixed settling window, the block combines the counts into a signed code. It presents that code with the sign and a coarse overflow flag under a one-cycle valid pulse, and holds them until the next result.

Top module: `tdc_two_step`

## Requirements
- R1: While reset is active and just after it, `code_vld`, `anlg_rst`, `code_neg`, `code_ovf` are 0 and `code_out` is 0.
- R2: A `conv_req` sampled while idle drives `anlg_rst` high for exactly one clock cycle in the next cycle. A `conv_req` during a conversion is ignored: it causes no extra `anlg_rst` pulse and no extra result.
- R3: `code_neg` is 1 when `cmp_ref` rose before `cmp_sen`, and 0 when `cmp_sen` rose first.
- R4: The coarse count Dc equals the number of rising clock edges strictly between the first and the second comparator edge.
- R5: The top bit of the leading fine code is 1 exactly when the clock was high at the first comparator edge. The top bit of the trailing fine code is 1 exactly when the clock was high at the second comparator edge.
- R6: The low 3 bits of each fine code equal the number of rising clock edges at which the corresponding stretcher busy input (`strf_busy` leading, `strb_busy` trailing) was held high. The count saturates at 7.
- R7: `code_out` is the 9-bit two's complement value 16·Dc + (Dff − Dfb). Here each fine code is {top bit, 3 counted bits}.
- R8: Dc saturates at 15. `code_ovf` is 1 in a result exactly when 16 or more whole periods were counted.
- R9: `code_vld` is high for one cycle per conversion. `code_out`, `code_neg` and `code_ovf` keep their value until the next `code_vld`.
- R10: Comparator edges that arrive while the block is idle produce no result, leave the outputs unchanged, and do not affect the sign of the next conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; all counters run from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_req | input | 1 | Conversion request, honoured only when idle |
| cmp_sen | input | 1 | Sensor-side comparator output, asynchronous rising edge |
| cmp_ref | input | 1 | Reference-side comparator output, asynchronous rising edge |
| strf_busy | input | 1 | Leading-fragment stretcher active, asynchronous |
| strb_busy | input | 1 | Trailing-fragment stretcher active, asynchronous |
| anlg_rst | output | 1 | One-cycle discharge/precharge command to the analog front end |
| code_out | output | 9 | Signed interval code 16·Dc + (Dff − Dfb) |
| code_neg | output | 1 | Sign: 1 when the reference comparator fired first |
| code_ovf | output | 1 | Coarse count saturated during this conversion |
| code_vld | output | 1 | One-cycle result strobe |

## Verification
Each internal register is visible in the next result. A stuck or miscleared coarse counter shifts `code_out` by multiples of 16 at the very next `code_vld`. A wrong top-bit latch shows up as an error of exactly 8. A fine counter that wraps or counts outside its window shows up as a small error in the low bits. A sign or edge-capture flop that is not cleared while idle corrupts `code_neg` on the following conversion. Faults in the controller's sequencing show up within one cycle, as a missing or doubled `anlg_rst` pulse or `code_vld` strobe. Result values are checked against a model of the formula under varied sub-period edge offsets, stretch lengths, both edge orders and the saturation limits.

// File: rtl/tdc_pkg.sv
`timescale 1ns/1ps
package tdc_pkg;

   // Controller sequence; the order is the conversion order.
   typedef enum logic [2:0] {
      ST_IDLE       = 3'd0,
      ST_ARM_RST    = 3'd1,
      ST_WAIT_FIRST = 3'd2,
      ST_COARSE     = 3'd3,
      ST_STRETCH    = 3'd4,
      ST_DONE       = 3'd5
   } tdc_state_e;

   // Fine path selectors used by the generate loops.
   localparam int FP_LEAD  = 0;
   localparam int FP_TRAIL = 1;
   localparam int N_FINE   = 2;

endpackage

// File: rtl/tdc_sync.sv
`timescale 1ns/1ps
module tdc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_single
         logic s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= 1'b0;
            else        s_q <= d;
         end
         assign q = s_q;
      end else begin : g_chain
         logic [STAGES-1:0] sr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr_q <= '0;
            else        sr_q <= {sr_q[STAGES-2:0], d};
         end
         assign q = sr_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/tdc_sat_cnt.sv
`timescale 1ns/1ps
module tdc_sat_cnt #(
   parameter int W        = 3,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);

   localparam logic [W-1:0] CNT_MAX = '1;

   logic [W-1:0] cnt_q;
   logic [W-1:0] cnt_nx;

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            cnt_nx = cnt_q;
            if (inc && (cnt_q != CNT_MAX)) cnt_nx = cnt_q + 1'b1;
         end
      end else begin : g_wrap
         always_comb begin
            cnt_nx = cnt_q;
            if (inc) cnt_nx = cnt_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else          cnt_q <= cnt_nx;
   end

   assign cnt = cnt_q;

endmodule

// File: rtl/tdc_edge_capture.sv
`timescale 1ns/1ps
module tdc_edge_capture (
   input  logic clk_lvl,
   input  logic clr,
   input  logic cmp_sen,
   input  logic cmp_ref,
   output logic first_seen,
   output logic second_seen,
   output logic ref_first,
   output logic msb_first,
   output logic msb_second
);

   // The earlier comparator opens the interval, the later one closes it.
   logic open_w;
   logic close_w;
   assign open_w  = cmp_sen | cmp_ref;
   assign close_w = cmp_sen & cmp_ref;

   // Interval opening: flag plus clock level at that instant.
   always_ff @(posedge open_w or posedge clr) begin
      if (clr) begin
         first_seen <= 1'b0;
         msb_first  <= 1'b0;
      end else begin
         first_seen <= 1'b1;
         msb_first  <= clk_lvl;
      end
   end

   // Interval closing.
   always_ff @(posedge close_w or posedge clr) begin
      if (clr) begin
         second_seen <= 1'b0;
         msb_second  <= 1'b0;
      end else begin
         second_seen <= 1'b1;
         msb_second  <= clk_lvl;
      end
   end

   // Order flop: reference already high when the sensor side rises.
   always_ff @(posedge cmp_sen or posedge clr) begin
      if (clr) ref_first <= 1'b0;
      else     ref_first <= cmp_ref;
   end

endmodule

// File: rtl/tdc_two_step.sv
`timescale 1ns/1ps
module tdc_two_step
   import tdc_pkg::*;
#(
   parameter int CW          = 4,
   parameter int FW          = 3,
   parameter int SYNC_STAGES = 2,
   parameter int SETTLE_CYC  = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             conv_req,
   input  logic             cmp_sen,
   input  logic             cmp_ref,
   input  logic             strf_busy,
   input  logic             strb_busy,
   output logic             anlg_rst,
   output logic [CW+FW+1:0] code_out,
   output logic             code_neg,
   output logic             code_ovf,
   output logic             code_vld
);

   localparam int FINE_W = FW + 1;
   localparam int OUT_W  = CW + FINE_W + 1;
   localparam int SET_W  = $clog2(SETTLE_CYC + 1);
   localparam int N_SYNC = 2 + N_FINE;
   localparam logic [CW-1:0]    DC_MAX     = '1;
   localparam logic [SET_W-1:0] SETTLE_END = SET_W'(SETTLE_CYC - 1);

   // Elaboration-time parameter checks
   generate
      if (CW < 1) begin : g_bad_cw
         $error("tdc_two_step: CW must be at least 1");
      end
      if (FW < 1) begin : g_bad_fw
         $error("tdc_two_step: FW must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tdc_two_step: SYNC_STAGES must be at least 2");
      end
      if (SETTLE_CYC <= (1 << FW)) begin : g_bad_settle
         $error("tdc_two_step: SETTLE_CYC must exceed the longest stretch");
      end
   endgenerate

   tdc_state_e state_q, state_nx;
   logic       clr_q;
   logic       arst_q;

   // Asynchronous edge capture
   logic first_raw, second_raw, ref_first, msb_first, msb_second;

   tdc_edge_capture u_cap (
      .clk_lvl     (clk),
      .clr         (clr_q),
      .cmp_sen     (cmp_sen),
      .cmp_ref     (cmp_ref),
      .first_seen  (first_raw),
      .second_seen (second_raw),
      .ref_first   (ref_first),
      .msb_first   (msb_first),
      .msb_second  (msb_second)
   );

   // Synchronizers: [0] open, [1] close, [2] lead busy, [3] trail busy
   logic [N_SYNC-1:0] raw_v;
   logic [N_SYNC-1:0] syn_v;
   assign raw_v = {strb_busy, strf_busy, second_raw, first_raw};

   generate
      for (genvar gi = 0; gi < N_SYNC; gi++) begin : g_sync
         tdc_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw_v[gi]),
            .q     (syn_v[gi])
         );
      end
   endgenerate

   logic first_s, second_s;
   assign first_s  = syn_v[0];
   assign second_s = syn_v[1];

   // Coarse counter over whole synchronized periods
   logic          dc_inc;
   logic [CW-1:0] dc_cnt;
   logic          dc_ovf_q;
   logic          conv_clr;

   assign conv_clr = (state_q == ST_ARM_RST);
   assign dc_inc   = ((state_q == ST_WAIT_FIRST) || (state_q == ST_COARSE))
                     && first_s && !second_s;

   tdc_sat_cnt #(.W(CW), .SATURATE(1'b1)) u_coarse (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (conv_clr),
      .inc   (dc_inc),
      .cnt   (dc_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          dc_ovf_q <= 1'b0;
      else if (conv_clr)                   dc_ovf_q <= 1'b0;
      else if (dc_inc && dc_cnt == DC_MAX) dc_ovf_q <= 1'b1;
   end

   // Fine counters: count while each stretcher reports busy
   logic          fine_en;
   logic [FW-1:0] fine_lsb [N_FINE];
   assign fine_en = (state_q == ST_COARSE) || (state_q == ST_STRETCH);

   generate
      for (genvar gf = 0; gf < N_FINE; gf++) begin : g_fine
         tdc_sat_cnt #(.W(FW), .SATURATE(1'b1)) u_fine (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (conv_clr),
            .inc   (fine_en && syn_v[2+gf]),
            .cnt   (fine_lsb[gf])
         );
      end
   endgenerate

   // Settling window after the closing edge is seen
   logic [SET_W-1:0] settle_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     settle_q <= '0;
      else if (state_q == ST_STRETCH) settle_q <= settle_q + 1'b1;
      else                            settle_q <= '0;
   end

   // Sequencer
   always_comb begin
      state_nx = state_q;
      unique case (state_q)
         ST_IDLE:       if (conv_req) state_nx = ST_ARM_RST;
         ST_ARM_RST:    state_nx = ST_WAIT_FIRST;
         ST_WAIT_FIRST: if (first_s) state_nx = second_s ? ST_STRETCH : ST_COARSE;
         ST_COARSE:     if (second_s) state_nx = ST_STRETCH;
         ST_STRETCH:    if (settle_q == SETTLE_END) state_nx = ST_DONE;
         ST_DONE:       state_nx = ST_IDLE;
         default:       state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         clr_q   <= 1'b1;
         arst_q  <= 1'b0;
      end else begin
         state_q <= state_nx;
         clr_q   <= (state_nx == ST_IDLE) || (state_nx == ST_ARM_RST);
         arst_q  <= (state_nx == ST_ARM_RST);
      end
   end

   assign anlg_rst = arst_q;

   // Encoder: Dc * 2^FINE_W + Dlead - Dtrail
   logic [FINE_W-1:0] d_lead, d_trail;
   logic [OUT_W-1:0]  coarse_term, lead_term, trail_term, code_nx;

   assign d_lead      = {msb_first,  fine_lsb[FP_LEAD]};
   assign d_trail     = {msb_second, fine_lsb[FP_TRAIL]};
   assign coarse_term = {1'b0, dc_cnt, {FINE_W{1'b0}}};
   assign lead_term   = {{(OUT_W-FINE_W){1'b0}}, d_lead};
   assign trail_term  = {{(OUT_W-FINE_W){1'b0}}, d_trail};
   assign code_nx     = coarse_term + lead_term - trail_term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_out <= '0;
         code_neg <= 1'b0;
         code_ovf <= 1'b0;
         code_vld <= 1'b0;
      end else begin
         code_vld <= (state_q == ST_DONE);
         if (state_q == ST_DONE) begin
            code_out <= code_nx;
            code_neg <= ref_first;
            code_ovf <= dc_ovf_q;
         end
      end
   end

endmodule

// File: rtl/tdc_two_step_chk.sv
`timescale 1ns/1ps
module tdc_two_step_chk
   import tdc_pkg::*;
#(
   parameter int CW = 4,
   parameter int FW = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             conv_req,
   input logic             anlg_rst,
   input logic             code_vld,
   input logic             code_ovf,
   input logic [CW+FW+1:0] code_out,
   input tdc_state_e       state_q,
   input logic [CW-1:0]    dc_cnt
);

   localparam int FINE_SPAN = 1 << (FW + 1);
   localparam int OVF_FLOOR = ((1 << CW) - 1) * FINE_SPAN - (FINE_SPAN - 1);

   // R2: discharge command lasts a single cycle
   assert_arst_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      anlg_rst |=> !anlg_rst);

   // R2: discharge command only follows a request taken while idle
   assert_arst_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(anlg_rst) |-> ($past(conv_req) && $past(state_q == ST_IDLE)));

   // R2: an idle request always starts a conversion
   assert_req_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req && state_q == ST_IDLE) |=> anlg_rst);

   // R9: result strobe is a single-cycle pulse
   assert_vld_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      code_vld |=> !code_vld);

   // R9: result word is held between strobes
   assert_code_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !code_vld |-> $stable(code_out));

   // R4: coarse count frozen once the closing edge is seen
   assert_coarse_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_STRETCH) |=> $stable(dc_cnt));

   // R8: an overflowed result carries the saturated coarse weight
   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (code_vld && code_ovf) |-> ($signed(code_out) >= OVF_FLOOR));

endmodule

bind tdc_two_step tdc_two_step_chk #(.CW(CW), .FW(FW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .conv_req (conv_req),
   .anlg_rst (anlg_rst),
   .code_vld (code_vld),
   .code_ovf (code_ovf),
   .code_out (code_out),
   .state_q  (state_q),
   .dc_cnt   (dc_cnt)
);

// File: tb/tdc_two_step_test.sv
`timescale 1ns/1ps
module tdc_two_step_test;

   logic       clk;
   logic       rst_n;
   logic       conv_req;
   logic       cmp_sen;
   logic       cmp_ref;
   logic       strf_busy;
   logic       strb_busy;
   logic       anlg_rst;
   logic [8:0] code_out;
   logic       code_neg;
   logic       code_ovf;
   logic       code_vld;

   tdc_two_step uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .conv_req  (conv_req),
      .cmp_sen   (cmp_sen),
      .cmp_ref   (cmp_ref),
      .strf_busy (strf_busy),
      .strb_busy (strb_busy),
      .anlg_rst  (anlg_rst),
      .code_out  (code_out),
      .code_neg  (code_neg),
      .code_ovf  (code_ovf),
      .code_vld  (code_vld)
   );

   typedef struct {
      int   code;
      logic neg;
      logic ovf;
   } exp_t;

   exp_t q_exp[$];
   int   total = 0;
   int   bad   = 0;
   int   arst_seen = 0;
   int   conv_sent = 0;
   int   last_code = 0;
   bit   finished  = 1'b0;

   initial begin
      clk = 1'b0;
      forever #5 clk = ~clk;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   // Model of one stretcher: busy for n clocks after the fragment ends
   task automatic stretch(input bit back, input int n);
      if (n > 0) begin
         @(posedge clk);
         @(negedge clk);
         if (back) strb_busy = 1'b1; else strf_busy = 1'b1;
         repeat (n) @(negedge clk);
         if (back) strb_busy = 1'b0; else strf_busy = 1'b0;
      end
   endtask

   function automatic int min_i(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   // Monitor: count discharge pulses, pop and compare results
   always @(negedge clk) begin
      if (rst_n && anlg_rst) arst_seen++;
      if (rst_n && code_vld) begin
         if (q_exp.size() == 0) begin
            chk(1'b0, "R10", "unexpected result strobe", 1, 0);
         end else begin
            exp_t e;
            e = q_exp.pop_front();
            chk($signed(code_out) == e.code, "R7", "code", $signed(code_out), e.code);
            chk(code_neg == e.neg, "R3", "sign", int'(code_neg), int'(e.neg));
            chk(code_ovf == e.ovf, "R8", "overflow", int'(code_ovf), int'(e.ovf));
         end
      end
   end

   // Driver: one conversion. Offsets o1/o2 are ns after a rising edge (period 10).
   task automatic do_conv(input bit ref_1st, input int k, input int o1, input int o2,
                          input int nf, input int nb, input bit extra_req);
      exp_t e;
      int   dc, dff, dfb;
      dc  = min_i(k, 15);
      dff = ((o1 < 5) ? 8 : 0) + min_i(nf, 7);   // R5, R6
      dfb = ((o2 < 5) ? 8 : 0) + min_i(nb, 7);   // R5, R6
      e.code = 16 * dc + dff - dfb;              // R4, R7
      e.neg  = ref_1st;
      e.ovf  = (k >= 16);
      q_exp.push_back(e);

      @(negedge clk) conv_req = 1'b1;
      @(negedge clk) conv_req = 1'b0;
      conv_sent++;
      chk(anlg_rst == 1'b1, "R2", "discharge asserted", int'(anlg_rst), 1);
      @(negedge clk);
      chk(anlg_rst == 1'b0, "R2", "discharge one cycle", int'(anlg_rst), 0);

      @(posedge clk);
      #(o1);
      if (ref_1st) cmp_ref = 1'b1; else cmp_sen = 1'b1;
      fork
         stretch(1'b0, nf);
      join_none
      if (k == 0) begin
         #(o2 - o1);
      end else begin
         repeat (k) @(posedge clk);
         #(o2);
      end
      if (ref_1st) cmp_sen = 1'b1; else cmp_ref = 1'b1;
      fork
         stretch(1'b1, nb);
      join_none

      if (extra_req) begin
         @(negedge clk) conv_req = 1'b1;
         @(negedge clk) conv_req = 1'b0;
      end

      do @(negedge clk); while (!code_vld);
      last_code = e.code;
      repeat (3) @(negedge clk);
      chk($signed(code_out) == e.code, "R9", "code held", $signed(code_out), e.code);
      chk(code_vld == 1'b0, "R9", "strobe single", int'(code_vld), 0);
      chk(arst_seen == conv_sent, "R2", "discharge pulse count", arst_seen, conv_sent);
      cmp_sen = 1'b0;
      cmp_ref = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      rst_n     = 1'b0;
      conv_req  = 1'b0;
      cmp_sen   = 1'b0;
      cmp_ref   = 1'b0;
      strf_busy = 1'b0;
      strb_busy = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(code_vld == 1'b0, "R1", "valid in reset", int'(code_vld), 0);
      chk(anlg_rst == 1'b0, "R1", "discharge in reset", int'(anlg_rst), 0);
      chk(code_out == 9'd0, "R1", "code in reset", int'(code_out), 0);
      chk(code_neg == 1'b0 && code_ovf == 1'b0, "R1", "flags in reset",
          int'({code_neg, code_ovf}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(code_vld == 1'b0 && anlg_rst == 1'b0, "R1", "idle after reset",
          int'({code_vld, anlg_rst}), 0);

      // R4 R5 R6 R7: directed cases
      do_conv(1'b0, 3, 2, 7, 5, 2, 1'b0);   // 48 + 13 - 2
      do_conv(1'b1, 0, 3, 8, 4, 1, 1'b0);   // R3: reference first, same period
      do_conv(1'b0, 5, 7, 2, 1, 6, 1'b0);   // trailing top bit set
      do_conv(1'b1, 0, 6, 9, 0, 3, 1'b0);   // negative code
      do_conv(1'b0, 2, 4, 1, 9, 0, 1'b0);   // R6: leading fine saturates
      do_conv(1'b0, 1, 8, 3, 0, 11, 1'b0);  // R6: trailing fine saturates
      do_conv(1'b1, 15, 1, 6, 2, 2, 1'b0);  // R8: 15 periods, no overflow
      do_conv(1'b0, 17, 9, 4, 3, 0, 1'b0);  // R8: saturated coarse, overflow
      do_conv(1'b1, 4, 2, 3, 6, 6, 1'b1);   // R2: request mid-conversion ignored

      // R10: comparator activity while idle
      repeat (2) @(negedge clk);
      #2 cmp_ref = 1'b1;
      #3 cmp_sen = 1'b1;
      repeat (4) @(negedge clk);
      cmp_sen = 1'b0;
      cmp_ref = 1'b0;
      repeat (3) @(negedge clk);
      chk($signed(code_out) == last_code, "R10", "code unchanged after idle edges",
          $signed(code_out), last_code);
      chk(arst_seen == conv_sent, "R10", "no discharge from idle edges",
          arst_seen, conv_sent);
      do_conv(1'b0, 2, 3, 3, 1, 1, 1'b0);   // R10: sign must be 0

      // R7: varied offsets and lengths
      for (int i = 0; i < 14; i++) begin
         int k, o1, o2, nf, nb;
         bit rf;
         k  = $urandom_range(0, 10);
         o1 = $urandom_range(1, 8);
         if (o1 >= 5) o1 = o1 + 1;
         o2 = $urandom_range(1, 8);
         if (o2 >= 5) o2 = o2 + 1;
         if (k == 0 && o2 <= o1) begin
            o1 = 1;
            o2 = 9;
         end
         nf = $urandom_range(0, 8);
         nb = $urandom_range(0, 8);
         rf = 1'($urandom_range(0, 1));
         do_conv(rf, k, o1, o2, nf, nb, 1'b0);
      end

      repeat (5) @(negedge clk);
      chk(q_exp.size() == 0, "R9", "all results delivered", q_exp.size(), 0);
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule